// File: doc/BRIEF.md
# GPIO pull-resistor programming latch

This block holds the pull-resistor setting (none, pull-down or pull-up) for a parameterised set of GPIO pins, 54 by default, arranged as 32-pin banks. Software never writes a pin's setting directly. It first loads a shared 2-bit pull code into a control register. It then sets the pins' bits in a per-bank strobe register. Later it clears those bits again. A pin takes the new code only when the whole sequence obeyed a minimum setup time and a minimum hold time, both counted in core clock cycles (150 each by default). If either time is too short, the pin keeps its previous setting.

Access uses a simple synchronous port: one address, a write enable and a read enable. Read data is registered and appears the cycle after the read enable. The per-pin settings leave the block as a flat bus of 2-bit codes, each driven directly from a flop.

Top module: `gpio_pull_latch`

## Requirements
- R1: After reset every pin's pull code is 0 (none), and the control register and both strobe registers read as 0.
- R2: Address 0 is the control register. A write keeps only wdata[1:0]. A read returns that value in rdata[1:0] with all upper bits 0, on the cycle after rd_en.
- R3: Addresses 1 and 2 are the strobe registers for banks 0 and 1. Bit n of bank b belongs to pin 32*b+n. A read returns the last written value of the bank.
- R4: Strobe bits that name no pin are dropped. In bank 1 these are bits 22 to 31: they read back as 0 and change no pin.
- R5: Pull codes are 0 = none, 1 = pull-down, 2 = pull-up. A valid sequence stores the control value that was in force when the pin's strobe bit rose. It is stored by the write that clears the bit and is visible on the pull output in the cycle after that write. Later control writes while the bit is high do not change what is stored.
- R6: The setup rule is met only if the write that raises a strobe bit comes at least SETUP_CYC clock edges after the last control write. With one edge fewer, the pin keeps its old code.
- R7: The hold rule is met only if the write that clears a strobe bit comes at least HOLD_CYC edges after the write that raised it. With one edge fewer, the pin keeps its old code.
- R8: Control code 3 is reserved. A sequence made with it leaves the pin unchanged, so no pin ever outputs code 3.
- R9: The pull outputs change only on a strobe-register write that clears bits. Control writes and idle cycles never change them.
- R10: Several pins, including pins in both banks, can be programmed in one sequence. Each pin's timing is judged from its own rise and fall writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (2) | Register address: 0 control, 1 bank 0 strobe, 2 bank 1 strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data, valid the cycle after rd_en |
| pull_state | output | 2*NUM_PINS (108) | Pull code of pin p in bits [2p+1:2p] |

## Verification
On every cycle the assertions check several invariants. No pin ever shows the reserved code. The pull bus stays frozen across idle cycles and control writes. Reset clears the bus. Reads of the control register and of the partial bank carry no stray upper bits. Which code a pin finally takes depends on exact cycle distances between separate writes. That can only be shown by the bench's sequences: the setup and hold boundaries one edge either side, capture of the code at the rising write, the reserved code, and multi-pin sequences across the bank split. A behavioural model follows these on every clock.

// File: rtl/gpio_pull_pkg.sv
package gpio_pull_pkg;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_code_e;

  localparam int CTRL_ADDR = 0;
  localparam int BANK_BASE_ADDR = 1;

  function automatic int bank_count(input int pins, input int bank_w);
    return (pins + bank_w - 1) / bank_w;
  endfunction

endpackage

// File: rtl/gpio_pull_regfile.sv
module gpio_pull_regfile
  import gpio_pull_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int SETUP_CYC = 150
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] strobe_bits,
  output logic [DATA_W-1:0]   rdata,
  output pull_code_e          ctrl_code,
  output logic                setup_met,
  output logic [NUM_PINS-1:0] pin_wr,
  output logic [NUM_PINS-1:0] pin_val
);

  localparam int BANK_W    = DATA_W;
  localparam int NUM_BANKS = bank_count(NUM_PINS, BANK_W);
  localparam int PAD_W     = NUM_BANKS * BANK_W - NUM_PINS;
  localparam int AGE_W     = $clog2(SETUP_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETUP_CYC);

  logic             ctrl_wr;
  logic [AGE_W-1:0] age_q;
  logic [NUM_BANKS*BANK_W-1:0] padded;
  logic [DATA_W-1:0] rd_word;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_code <= PULL_NONE;
    end else if (ctrl_wr) begin
      ctrl_code <= pull_code_e'(wdata[1:0]);
    end
  end

  // cycles since last control write, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= AGE_MAX;
    end else if (ctrl_wr) begin
      age_q <= AGE_W'(1);
    end else if (age_q != AGE_MAX) begin
      age_q <= age_q + AGE_W'(1);
    end
  end

  assign setup_met = (age_q == AGE_MAX);

  // per-pin write strobes
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_dec
    localparam int PB = p / BANK_W;
    localparam int PN = p % BANK_W;
    assign pin_wr[p]  = wr_en && (addr == ADDR_W'(BANK_BASE_ADDR + PB));
    assign pin_val[p] = wdata[PN];
  end

  // readback view of strobe bits
  if (PAD_W > 0) begin : g_pad
    assign padded = {{PAD_W{1'b0}}, strobe_bits};
  end else begin : g_nopad
    assign padded = strobe_bits;
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rd_word[1:0] = ctrl_code;
    end
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(BANK_BASE_ADDR + b)) begin
        rd_word = padded[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end
  end

endmodule

// File: rtl/gpio_pull_pin.sv
module gpio_pull_pin
  import gpio_pull_pkg::*;
#(
  parameter int HOLD_CYC = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       wr_val,
  input  pull_code_e ctrl_code,
  input  logic       setup_met,
  output logic       strobe,
  output pull_code_e pull
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_CYC);

  logic              rise, fall;
  logic              armed_q;
  pull_code_e        cap_q;
  logic [HOLD_W-1:0] hold_q;

  assign rise = wr_stb &&  wr_val && !strobe;
  assign fall = wr_stb && !wr_val &&  strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe  <= 1'b0;
      armed_q <= 1'b0;
      cap_q   <= PULL_NONE;
      hold_q  <= '0;
      pull    <= PULL_NONE;
    end else begin
      if (wr_stb) begin
        strobe <= wr_val;
      end
      if (rise) begin
        cap_q   <= ctrl_code;
        armed_q <= setup_met && (ctrl_code != PULL_RSVD);
        hold_q  <= HOLD_W'(1);
      end else if (strobe && hold_q != HOLD_MAX) begin
        hold_q <= hold_q + HOLD_W'(1);
      end
      if (fall && armed_q && hold_q == HOLD_MAX) begin
        pull <= cap_q;
      end
    end
  end

endmodule

// File: rtl/gpio_pull_latch.sv
module gpio_pull_latch
  import gpio_pull_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int SETUP_CYC = 150,
  parameter int HOLD_CYC  = 150
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [2*NUM_PINS-1:0] pull_state
);

  pull_code_e          ctrl_code;
  logic                setup_met;
  logic [NUM_PINS-1:0] pin_wr, pin_val, strobe_bits;
  pull_code_e          pin_pull [NUM_PINS];

  gpio_pull_regfile #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SETUP_CYC(SETUP_CYC)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .strobe_bits(strobe_bits),
    .rdata      (rdata),
    .ctrl_code  (ctrl_code),
    .setup_met  (setup_met),
    .pin_wr     (pin_wr),
    .pin_val    (pin_val)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pull_pin #(.HOLD_CYC(HOLD_CYC)) u_pin (
      .clk      (clk),
      .rst      (rst),
      .wr_stb   (pin_wr[p]),
      .wr_val   (pin_val[p]),
      .ctrl_code(ctrl_code),
      .setup_met(setup_met),
      .strobe   (strobe_bits[p]),
      .pull     (pin_pull[p])
    );
    assign pull_state[2*p +: 2] = pin_pull[p];
  end

endmodule

// File: rtl/gpio_pull_latch_chk.sv
module gpio_pull_latch_chk #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     rdata,
  input logic [2*NUM_PINS-1:0] pull_state
);

  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int TOP_VALID = NUM_PINS - (NUM_BANKS - 1) * DATA_W;

  p_reset_none_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pull_state == '0));

  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(addr) == '0) |-> (rdata[DATA_W-1:2] == '0));

  p_ctrl_inert_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr) == '0) |-> $stable(pull_state));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(pull_state));

  if (TOP_VALID < DATA_W) begin : g_mask
    p_top_bank_mask_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd_en) && $past(addr) == ADDR_W'(NUM_BANKS))
      |-> (rdata[DATA_W-1:TOP_VALID] == '0));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_rsvd
    p_no_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
      pull_state[2*p +: 2] != 2'd3);
  end

endmodule

bind gpio_pull_latch gpio_pull_latch_chk #(
  .NUM_PINS(NUM_PINS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .pull_state(pull_state)
);

// File: tb/tb_gpio_pull_latch.sv
`timescale 1ns/1ps
module tb_gpio_pull_latch;

  localparam int NP = 54;
  localparam int S  = 150;
  localparam int H  = 150;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [2*NP-1:0] pull_state;

  int errors = 0;
  int checks = 0;

  gpio_pull_latch dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pull_state(pull_state)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_pull [NP];
  int m_bit  [NP];
  int m_cap  [NP];
  int m_rise [NP];
  int m_ok   [NP];
  int m_ctrl, m_ctrl_t;
  longint cyc = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_pull[p] = 0; m_bit[p] = 0; m_cap[p] = 0; m_rise[p] = 0; m_ok[p] = 0;
      end
      m_ctrl = 0;
      m_ctrl_t = -1000000;
    end else if (wr_en) begin
      if (addr == 2'd0) begin
        m_ctrl = int'(wdata & 32'd3);
        m_ctrl_t = int'(cyc);
      end else if (addr == 2'd1 || addr == 2'd2) begin
        for (int n = 0; n < 32; n++) begin
          int p;
          int nb;
          p = (int'(addr) - 1) * 32 + n;
          if (p < NP) begin
            nb = int'(wdata[n]);
            if (m_bit[p] == 0 && nb == 1) begin
              m_rise[p] = int'(cyc);
              m_cap[p]  = m_ctrl;
              m_ok[p]   = (int'(cyc) - m_ctrl_t >= S) ? 1 : 0;
            end else if (m_bit[p] == 1 && nb == 0) begin
              if (m_ok[p] == 1 && m_cap[p] != 3 && int'(cyc) - m_rise[p] >= H)
                m_pull[p] = m_cap[p];
            end
            m_bit[p] = nb;
          end
        end
      end
    end
    cyc++;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // compare against model every cycle
  always @(negedge clk) begin
    if (!rst) begin
      int bad;
      bad = -1;
      for (int p = 0; p < NP; p++)
        if (bad < 0 && int'(pull_state[2*p +: 2]) != m_pull[p]) bad = p;
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL R9 model pin %0d act=%0d exp=%0d", bad,
                 int'(pull_state[2*bad +: 2]), m_pull[bad]);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; addr = 2'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pin(input int p);
    return int'(pull_state[2*p +: 2]);
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all requirements act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    check("R1 pull bus zero", int'(pull_state == '0), 1);
    rd(0, d); check("R1 ctrl reads 0", int'(d), 0);
    rd(1, d); check("R1 bank0 reads 0", int'(d), 0);
    rd(2, d); check("R1 bank1 reads 0", int'(d), 0);

    // R5 pull-up on pin 3
    wr(0, 32'd2); idle(S-1);
    wr(1, 32'h8); idle(H-1);
    wr(1, 32'h0);
    check("R5 pin3 pull-up", pin(3), 2);
    check("R5 pin2 untouched", pin(2), 0);

    // R3 readback; short hold leaves pins alone (R7)
    wr(1, 32'hA5A5_0F0F);
    rd(1, d); check("R3 bank0 readback", int'(d == 32'hA5A5_0F0F), 1);
    wr(1, 32'h0);
    check("R7 short pulse no change pin0", pin(0), 0);
    check("R7 short pulse pin3 kept", pin(3), 2);

    // R6 setup one edge short
    wr(0, 32'd1); idle(S-2);
    wr(1, 32'h8); idle(H-1);
    wr(1, 32'h0);
    check("R6 setup short keeps pin3", pin(3), 2);

    // R6 setup exact
    wr(0, 32'd1); idle(S-1);
    wr(1, 32'h8); idle(H-1);
    wr(1, 32'h0);
    check("R6 setup exact pin3 pull-down", pin(3), 1);

    // R7 hold one edge short
    wr(0, 32'd0); idle(S-1);
    wr(1, 32'h8); idle(H-2);
    wr(1, 32'h0);
    check("R7 hold short keeps pin3", pin(3), 1);

    // R2 and R8 reserved code
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R2 ctrl keeps low bits", int'(d), 3);
    idle(S-2);
    wr(1, 32'h8); idle(H-1);
    wr(1, 32'h0);
    check("R8 reserved keeps pin3", pin(3), 1);

    // R10 straddling both banks
    wr(0, 32'd2); idle(S-1);
    wr(1, 32'hF000_0000);
    wr(2, 32'h0000_3FFF);
    idle(H-1);
    wr(1, 32'h0);
    wr(2, 32'h0);
    check("R10 pin28 pull-up", pin(28), 2);
    check("R10 pin45 pull-up", pin(45), 2);
    check("R10 pin27 untouched", pin(27), 0);
    check("R10 pin46 untouched", pin(46), 0);

    // R4 upper bank1 bits
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check("R4 bank1 masked readback", int'(d == 32'h003F_FFFF), 1);
    idle(H-2);
    wr(2, 32'h0);
    check("R4 pin53 pull-up", pin(53), 2);
    rd(2, d); check("R4 bank1 cleared", int'(d), 0);

    // R5 capture at rise; R9 control write inert
    wr(0, 32'd1); idle(S-1);
    wr(1, 32'h1);
    wr(0, 32'd2);
    check("R9 ctrl write leaves pin0", pin(0), 0);
    idle(H-2);
    wr(1, 32'h0);
    check("R5 captured code at rise pin0", pin(0), 1);

    // R1 reset again
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    check("R1 re-reset pull bus zero", int'(pull_state == '0), 1);
    rd(0, d); check("R1 re-reset ctrl", int'(d), 0);

    idle(2);
    summary();
    $finish;
  end

endmodule